// File: doc/BRIEF.md
# Front-End Branch Resolve and Redirect

This block is the fetch and decode front end of a seven-stage scalar pipeline. It covers the translate, cache-access and decode stages. It holds the program counter. Each cycle it picks the next fetch address from a predictor's taken flag and target. The block passes the prediction and the fall-through address down two pipeline registers, and each of those registers has a synchronous clear and an enable.

In decode the block recognises the branch-if-equal instruction and compares the two source operands. It then forms the branch target from the decode-stage fall-through address and the word-scaled immediate, and checks that target against the predicted one. When the prediction was wrong, both pipeline registers are cleared, which cancels the two younger fetches. The fetch address is then redirected, so a wrong guess costs exactly two cycles. Four resolution bits go back to the predictor for its update.

The translation buffer, the instruction cache, the register file and the branch history table are stubs outside the block. The block puts the fetch and cache-stage addresses and the register numbers on its ports, and it receives their answers in the same cycle. A stall input from the hazard logic freezes the front end.

Top module: `fe_branch_redirect`

## Requirements
- R1: While rst_ni is low, pc_o equals RESET_PC (default 32'h0000_0100), dec_valid_o is 0 and mispredict_o is 0.
- R2: In a cycle with no stall and no misprediction, the next pc_o is pred_target_i when pred_taken_i is 1, and pc_o+4 otherwise.
- R3: fb_branch_o is 1 only for a valid decode-stage instruction whose bits 31:26 equal 6'b000100. Any other opcode, including 6'b000101, leaves it 0 and never causes a misprediction.
- R4: The computed target is the decode-stage PC+4 plus the sign-extended immediate (bits 15:0) shifted left by two. fb_tgt_ok_o is 1 when that target equals the predicted target carried from fetch.
- R5: A branch predicted taken is mispredicted when its operands differ (register fields rs at bits 25:21 and rt at bits 20:16) or when its target does not match. The next PC is then the computed target if the operands are equal, and the decode-stage PC+4 if they differ.
- R6: A branch predicted not taken is mispredicted when its operands are equal, and the next PC is then the computed target.
- R7: A misprediction clears both pipeline registers. Exactly two decode slots hold no valid instruction before the redirected instruction reaches decode.
- R8: A correctly predicted branch raises no misprediction, and the next instruction on the correct path reaches decode in the very next cycle.
- R9: While stall_i is 1 and there is no misprediction, pc_o and the decode-stage contents do not change.
- R10: Clear takes priority over enable. A misprediction raised while stall_i is 1 still flushes both registers and redirects the PC.
- R11: fb_ptaken_o, fb_regs_eq_o and fb_tgt_ok_o report the carried prediction flag, operand equality and target match for the instruction in decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| stall_i | input | 1 | Hazard stall; freezes PC and both pipeline registers |
| pred_taken_i | input | 1 | Predictor taken flag for pc_o |
| pred_target_i | input | 32 | Predictor target for pc_o |
| pc_o | output | 32 | Fetch address in the translate stage |
| ic_pc_o | output | 32 | Address of the instruction in the cache stage |
| ic_instr_i | input | 32 | Instruction word returned for ic_pc_o |
| rs_addr_o | output | 5 | First source register number in decode |
| rt_addr_o | output | 5 | Second source register number in decode |
| rs_data_i | input | 32 | Value of the first source register |
| rt_data_i | input | 32 | Value of the second source register |
| dec_valid_o | output | 1 | Decode stage holds a live instruction |
| dec_pc4_o | output | 32 | PC+4 of the instruction in decode |
| fb_branch_o | output | 1 | Decode instruction is branch-if-equal |
| fb_ptaken_o | output | 1 | Carried predicted-taken flag |
| fb_regs_eq_o | output | 1 | Source operands equal |
| fb_tgt_ok_o | output | 1 | Predicted target equals computed target |
| mispredict_o | output | 1 | Misprediction; flush and redirect at next edge |

## Verification
The bench targets all four ways a prediction can meet its outcome, plus a taken prediction with the wrong target, which a design checking only the flag would let run down the wrong path. A backward branch with a negative immediate exposes a missing sign extension, because the redirect would then land far ahead. A look-alike opcode one bit away from the branch code catches a loose opcode decode, which would flag a branch and flush for nothing. A multi-cycle stall on a branch in decode shows whether the PC or the decode contents slip. A stall that coincides with a misprediction shows whether the enable was allowed to override the clear, which would leave a wrong-path instruction alive.

// File: rtl/fe_pkg.sv
package fe_pkg;
  localparam int XLEN        = 32;
  localparam int REG_AW      = 5;
  localparam int OPC_W       = 6;
  localparam int IMM_W       = 16;
  localparam int INSTR_BYTES = 4;
  localparam int OPC_LSB     = XLEN - OPC_W;
  localparam int RS_LSB      = OPC_LSB - REG_AW;
  localparam int RT_LSB      = RS_LSB - REG_AW;
  localparam int IMM_SHIFT   = $clog2(INSTR_BYTES);

  typedef logic [XLEN-1:0] word_t;

  typedef struct packed {
    logic  valid;
    word_t pc;
    word_t pc4;
    logic  ptaken;
    word_t ptarget;
  } itic_t;

  typedef struct packed {
    logic  valid;
    word_t pc4;
    logic  ptaken;
    word_t ptarget;
    word_t instr;
  } icdec_t;
endpackage

// File: rtl/fe_pipe_reg.sv
module fe_pipe_reg #(
  parameter type T = logic
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  T     d_i,
  output T     q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (clr_i)  q_o <= '0;  // clear wins over enable
    else if (en_i)   q_o <= d_i;
  end
endmodule

// File: rtl/fe_pc_gen.sv
module fe_pc_gen
  import fe_pkg::*;
#(
  parameter word_t RESET_PC = 32'h0000_0100
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  stall_i,
  input  logic  redirect_i,
  input  word_t redirect_pc_i,
  input  logic  pred_taken_i,
  input  word_t pred_target_i,
  output word_t pc_o,
  output word_t pc4_o
);
  localparam word_t STEP = word_t'(INSTR_BYTES);

  assign pc4_o = pc_o + STEP;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pc_o <= RESET_PC;
    else if (redirect_i) pc_o <= redirect_pc_i;
    else if (!stall_i)   pc_o <= pred_taken_i ? pred_target_i : pc4_o;
  end

  p_pc_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_i && !redirect_i) |=> $stable(pc_o));
endmodule

// File: rtl/fe_br_resolve.sv
module fe_br_resolve
  import fe_pkg::*;
#(
  parameter logic [OPC_W-1:0] BEQ_OPC = 6'b000100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  icdec_t            dec_i,
  input  word_t             rs_data_i,
  input  word_t             rt_data_i,
  output logic [REG_AW-1:0] rs_addr_o,
  output logic [REG_AW-1:0] rt_addr_o,
  output logic              branch_o,
  output logic              ptaken_o,
  output logic              regs_eq_o,
  output logic              tgt_ok_o,
  output logic              mispredict_o,
  output word_t             redirect_pc_o
);
  localparam int EXT_W = XLEN - IMM_W - IMM_SHIFT;

  logic [OPC_W-1:0] opc;
  logic [IMM_W-1:0] imm;
  word_t            offset;
  word_t            target;
  logic             mis_taken, mis_untaken;

  assign opc       = dec_i.instr[XLEN-1:OPC_LSB];
  assign rs_addr_o = dec_i.instr[RS_LSB +: REG_AW];
  assign rt_addr_o = dec_i.instr[RT_LSB +: REG_AW];
  assign imm       = dec_i.instr[IMM_W-1:0];
  assign offset    = {{EXT_W{imm[IMM_W-1]}}, imm, {IMM_SHIFT{1'b0}}};
  assign target    = dec_i.pc4 + offset;

  assign branch_o  = dec_i.valid && (opc == BEQ_OPC);
  assign ptaken_o  = dec_i.ptaken;
  assign regs_eq_o = (rs_data_i == rt_data_i);
  assign tgt_ok_o  = (target == dec_i.ptarget);

  always_comb begin
    mis_taken    = branch_o &&  ptaken_o && (!tgt_ok_o || !regs_eq_o);
    mis_untaken  = branch_o && !ptaken_o && regs_eq_o;
    mispredict_o = mis_taken || mis_untaken;
    // actual outcome picks the restart point
    redirect_pc_o = regs_eq_o ? target : dec_i.pc4;
  end

  p_mis_is_branch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mispredict_o |-> branch_o);
  p_branch_live_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    branch_o |-> dec_i.valid);
  p_good_pred_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (branch_o && ptaken_o && regs_eq_o && tgt_ok_o) |-> !mispredict_o);
  p_untaken_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mispredict_o && !ptaken_o) |-> (redirect_pc_o == target));
endmodule

// File: rtl/fe_branch_redirect.sv
module fe_branch_redirect
  import fe_pkg::*;
#(
  parameter logic [XLEN-1:0]  RESET_PC = 32'h0000_0100,
  parameter logic [OPC_W-1:0] BEQ_OPC  = 6'b000100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stall_i,
  input  logic              pred_taken_i,
  input  logic [XLEN-1:0]   pred_target_i,
  output logic [XLEN-1:0]   pc_o,
  output logic [XLEN-1:0]   ic_pc_o,
  input  logic [XLEN-1:0]   ic_instr_i,
  output logic [REG_AW-1:0] rs_addr_o,
  output logic [REG_AW-1:0] rt_addr_o,
  input  logic [XLEN-1:0]   rs_data_i,
  input  logic [XLEN-1:0]   rt_data_i,
  output logic              dec_valid_o,
  output logic [XLEN-1:0]   dec_pc4_o,
  output logic              fb_branch_o,
  output logic              fb_ptaken_o,
  output logic              fb_regs_eq_o,
  output logic              fb_tgt_ok_o,
  output logic              mispredict_o
);
  word_t  it_pc4;
  word_t  redirect_pc;
  itic_t  itic_d, itic_q;
  icdec_t icdec_d, icdec_q;
  logic   flush, adv;

  assign flush = mispredict_o;
  assign adv   = !stall_i;

  fe_pc_gen #(.RESET_PC(RESET_PC)) u_pc_gen (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .stall_i       (stall_i),
    .redirect_i    (flush),
    .redirect_pc_i (redirect_pc),
    .pred_taken_i  (pred_taken_i),
    .pred_target_i (pred_target_i),
    .pc_o          (pc_o),
    .pc4_o         (it_pc4)
  );

  always_comb begin
    itic_d.valid   = 1'b1;
    itic_d.pc      = pc_o;
    itic_d.pc4     = it_pc4;
    itic_d.ptaken  = pred_taken_i;
    itic_d.ptarget = pred_target_i;
  end

  fe_pipe_reg #(.T(itic_t)) u_itic (
    .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (flush), .en_i (adv),
    .d_i (itic_d), .q_o (itic_q)
  );

  assign ic_pc_o = itic_q.pc;

  always_comb begin
    icdec_d.valid   = itic_q.valid;
    icdec_d.pc4     = itic_q.pc4;
    icdec_d.ptaken  = itic_q.ptaken;
    icdec_d.ptarget = itic_q.ptarget;
    icdec_d.instr   = ic_instr_i;
  end

  fe_pipe_reg #(.T(icdec_t)) u_icdec (
    .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (flush), .en_i (adv),
    .d_i (icdec_d), .q_o (icdec_q)
  );

  assign dec_valid_o = icdec_q.valid;
  assign dec_pc4_o   = icdec_q.pc4;

  fe_br_resolve #(.BEQ_OPC(BEQ_OPC)) u_resolve (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .dec_i         (icdec_q),
    .rs_data_i     (rs_data_i),
    .rt_data_i     (rt_data_i),
    .rs_addr_o     (rs_addr_o),
    .rt_addr_o     (rt_addr_o),
    .branch_o      (fb_branch_o),
    .ptaken_o      (fb_ptaken_o),
    .regs_eq_o     (fb_regs_eq_o),
    .tgt_ok_o      (fb_tgt_ok_o),
    .mispredict_o  (mispredict_o),
    .redirect_pc_o (redirect_pc)
  );

  p_flush_two_slots_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mispredict_o |=> !dec_valid_o ##1 !dec_valid_o);
  p_redirect_pc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mispredict_o |=> (pc_o == $past(redirect_pc)));
  p_dec_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_i && !mispredict_o) |=> ($stable(dec_pc4_o) && $stable(dec_valid_o)));
  p_clear_beats_stall_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_i && mispredict_o) |=> !dec_valid_o);
endmodule

// File: tb/fe_branch_redirect_tb.sv
`timescale 1ns/1ps
module fe_branch_redirect_tb;
  localparam logic [31:0] RST_PC = 32'h0000_0100;
  localparam logic [31:0] BR_PC  = 32'h0000_0110;
  localparam logic [31:0] DECOY  = 32'h0000_0108;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic        rst_ni = 1'b0, stall = 1'b0;
  logic        pred_taken;
  logic [31:0] pred_target, pc_o, ic_pc_o, ic_instr, rs_data, rt_data, dec_pc4;
  logic [4:0]  rs_addr, rt_addr;
  logic        dec_valid, fb_branch, fb_ptaken, fb_eq, fb_tok, mis;

  logic        cfg_pt = 1'b0, cfg_eq = 1'b0;
  logic [31:0] cfg_ptgt = '0;
  logic [15:0] cfg_imm = '0;

  fe_branch_redirect u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .stall_i(stall),
    .pred_taken_i(pred_taken), .pred_target_i(pred_target),
    .pc_o(pc_o), .ic_pc_o(ic_pc_o), .ic_instr_i(ic_instr),
    .rs_addr_o(rs_addr), .rt_addr_o(rt_addr), .rs_data_i(rs_data), .rt_data_i(rt_data),
    .dec_valid_o(dec_valid), .dec_pc4_o(dec_pc4), .fb_branch_o(fb_branch),
    .fb_ptaken_o(fb_ptaken), .fb_regs_eq_o(fb_eq), .fb_tgt_ok_o(fb_tok),
    .mispredict_o(mis)
  );

  // stubs: predictor, cache, register file
  always_comb begin
    pred_taken  = (pc_o == BR_PC) && cfg_pt;
    pred_target = cfg_ptgt;
    if (ic_pc_o == BR_PC)      ic_instr = {6'b000100, 5'd1, cfg_eq ? 5'd1 : 5'd2, cfg_imm};
    else if (ic_pc_o == DECOY) ic_instr = {6'b000101, 5'd3, 5'd3, 16'h0010};
    else                       ic_instr = {6'b000000, 5'd3, 5'd4, 5'd5, 11'h020};
    rs_data = 32'h100 + {27'd0, rs_addr};
    rt_data = 32'h100 + {27'd0, rt_addr};
  end

  typedef struct {
    logic [31:0] pc4;
    int          gap;
    bit          is_br, mis, pt, eq, tok;
  } item_t;
  item_t q[$];

  int n_chk = 0, n_fail = 0;
  bit mon_en = 0, prev_ok = 0, prev_stall = 0, prev_mis = 0, prev_pt = 0;
  logic [31:0] prev_pc = '0, prev_tgt = '0;
  int gap = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // driver: architectural path from the requirements
  task automatic build(input int n);
    logic [31:0] pc, tgt;
    int g;
    bit taken;
    item_t it;
    pc = RST_PC; g = -1;
    q.delete();
    for (int i = 0; i < n; i++) begin
      it.pc4 = pc + 4; it.gap = g; it.is_br = (pc == BR_PC);
      it.pt = cfg_pt; it.eq = cfg_eq;
      tgt = pc + 4 + {{14{cfg_imm[15]}}, cfg_imm, 2'b00};
      it.tok = (cfg_ptgt == tgt);
      if (it.is_br) begin
        taken  = cfg_eq;
        it.mis = cfg_pt ? (!taken || !it.tok) : taken;
        g      = it.mis ? 2 : 0;
        pc     = taken ? tgt : pc + 4;
      end else begin
        it.mis = 0; g = 0; pc = pc + 4;
      end
      q.push_back(it);
    end
  endtask

  // monitor
  always begin
    @(negedge clk); #2;
    if (mon_en) begin
      if (prev_ok) begin
        if (prev_stall && !prev_mis) chk(pc_o == prev_pc, "R9 pc frozen", pc_o, prev_pc);
        else if (!prev_mis) chk(pc_o == (prev_pt ? prev_tgt : prev_pc + 4), "R2 next pc",
                                pc_o, prev_pt ? prev_tgt : prev_pc + 4);
      end
      if (dec_valid && (!stall || mis)) begin
        if (q.size() > 0) begin
          item_t it;
          it = q.pop_front();
          chk(dec_pc4 == it.pc4, "R7 path order", dec_pc4, it.pc4);
          if (it.gap >= 0)
            chk(gap == it.gap, it.gap == 2 ? "R7 penalty" : "R8 no bubble", gap, it.gap);
          chk(fb_branch == it.is_br, "R3 branch flag", {31'd0, fb_branch}, {31'd0, it.is_br});
          chk(mis == it.mis, it.is_br ? (it.pt ? "R5 taken resolve" : "R6 untaken resolve")
                                      : "R3 no mispredict", {31'd0, mis}, {31'd0, it.mis});
          if (it.is_br) begin
            chk(fb_ptaken == it.pt, "R11 ptaken", {31'd0, fb_ptaken}, {31'd0, it.pt});
            chk(fb_eq == it.eq, "R11 regs eq", {31'd0, fb_eq}, {31'd0, it.eq});
            chk(fb_tok == it.tok, "R4 target match", {31'd0, fb_tok}, {31'd0, it.tok});
          end
        end
        gap = 0;
      end else if (!dec_valid && !stall) gap++;
      prev_pc = pc_o; prev_pt = pred_taken; prev_tgt = pred_target;
      prev_mis = mis; prev_stall = stall; prev_ok = 1;
    end
  end

  task automatic run(input bit pt, input logic [31:0] ptgt, input bit eq,
                     input logic [15:0] imm, input int smode, input logic [31:0] rtgt);
    bit sdone;
    int cnt;
    logic [31:0] sp, sd;
    mon_en = 0; rst_ni = 0; stall = 0;
    cfg_pt = pt; cfg_ptgt = ptgt; cfg_eq = eq; cfg_imm = imm;
    build(12);
    repeat (2) @(negedge clk);
    chk(pc_o == RST_PC, "R1 reset pc", pc_o, RST_PC);
    chk(!dec_valid, "R1 reset valid", {31'd0, dec_valid}, 32'd0);
    chk(!mis, "R1 reset mispredict", {31'd0, mis}, 32'd0);
    prev_ok = 0; gap = 0; sdone = 0; cnt = 0;
    rst_ni = 1; mon_en = 1;
    while (q.size() > 0 && cnt < 400) begin
      @(negedge clk); cnt++;
      if (smode != 0 && !sdone && fb_branch) begin
        sdone = 1; stall = 1;
        if (smode == 1) begin
          sp = pc_o; sd = dec_pc4;
          for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(pc_o == sp, "R9 stall pc", pc_o, sp);
            chk(dec_pc4 == sd, "R9 stall decode", dec_pc4, sd);
          end
          stall = 0;
        end else begin
          @(negedge clk);
          chk(pc_o == rtgt, "R10 redirect under stall", pc_o, rtgt);
          chk(!dec_valid, "R10 flush under stall", {31'd0, dec_valid}, 32'd0);
          stall = 0;
        end
      end
    end
    chk(q.size() == 0, "R7 stream complete", q.size(), 0);
    @(negedge clk); mon_en = 0;
  endtask

  initial begin
    run(1, 32'h134, 1, 16'h0008, 0, 0);  // R8 taken, predicted taken
    run(0, 32'h134, 1, 16'h0008, 0, 0);  // R6 taken, predicted untaken
    run(1, 32'h134, 0, 16'h0008, 0, 0);  // R5 untaken, predicted taken
    run(0, 32'h134, 0, 16'h0008, 0, 0);  // R8 untaken, predicted untaken
    run(1, 32'h200, 1, 16'h0008, 0, 0);  // R5 R4 wrong target
    run(0, 32'h000, 1, 16'hFFFC, 0, 0);  // R4 backward loop
    run(1, 32'h134, 1, 16'h0008, 1, 0);  // R9 stall on branch
    run(0, 32'h134, 1, 16'h0008, 2, 32'h134);  // R10
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=%h exp=%h", 32'd1, 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule